// File: doc/BRIEF.md
# Configurable asynchronous serial transceiver

This block is a full-duplex asynchronous serial port. A transmit engine accepts one character at a time over a valid/ready handshake and shifts it onto a single output line. A receive engine oversamples the input line, rebuilds each character, and holds it in a one-entry register together with error flags that belong to that character. A single-cycle enable input, `tick16`, paces both directions at sixteen oversample ticks per bit.

Software chooses the character format at run time through four configuration inputs. These set the number of data bits, the parity scheme, a forced parity level, and the stop length. The block copies the inputs into an internal register only while both engines are idle, so a character already in flight keeps its format. The receiver flags wrong parity, a low stop bit, a line held low for a whole character, and a character lost because the previous one was still unread.

Top module: `serial_xcvr`

## Requirements
- R1: `txd` is high whenever the transmitter is idle. A frame is one low start bit followed by the data bits, least significant first. `cfg_len` codes 0, 1, 2 and 3 select 5, 6, 7 and 8 data bits. Every start, data and parity bit lasts 16 ticks.
- R2: A parity bit follows the data bits unless `cfg_par` is 0. Code 1 makes the total count of ones in data plus parity even. Code 2 makes that count odd. Code 3 sends the level of `cfg_stick`.
- R3: The stop level is high. `cfg_stop` code 0 gives 16 ticks, code 1 gives 24 ticks, and codes 2 and 3 give 32 ticks. The transmit frame lasts exactly 16·(1+data bits+parity bits) ticks plus the stop ticks.
- R4: `tx_ready` is high only while the transmitter is idle. A cycle with `tx_valid` and `tx_ready` both high accepts `tx_data`. In the next cycle `tx_ready` is low and `txd` is low.
- R5: The receiver passes `rxd` through two flops. It samples each bit at the ninth tick of the bit, counted from the first tick on which the synchronized line is low. It presents the character right-aligned in `rx_data` with the unused upper bits zero. `rx_valid` and `rx_data` hold until a cycle with `rx_read` high.
- R6: A low pulse on `rxd` that is gone by the mid-bit sample of the start bit produces no character.
- R7: `rx_perr` is set when the received parity bit differs from the bit that R2 would send for the received data. It is never set when parity is off.
- R8: `rx_ferr` is set when the first stop bit is sampled low.
- R9: When every sample of a character is low, including parity and stop, the character is delivered with data 0 and both `rx_brk` and `rx_ferr` set. No new start bit is searched for until `rxd` has returned high.
- R10: A character that completes while `rx_valid` is high and `rx_read` is low is dropped. In that case `rx_ovf` is set and the held data is kept. A read clears both `rx_valid` and `rx_ovf`.
- R11: The configuration inputs are captured only in cycles when neither engine is busy. A change made during a frame does not affect that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick16 | input | 1 | Oversample enable, 16 per bit time |
| cfg_len | input | 2 | Data length code (5 + code bits) |
| cfg_par | input | 2 | Parity scheme: none, even, odd, forced |
| cfg_stick | input | 1 | Level of the forced parity bit |
| cfg_stop | input | 2 | Stop length: 1, 1.5, 2 bit times |
| tx_data | input | 8 | Character to send |
| tx_valid | input | 1 | Transmit request |
| tx_ready | output | 1 | Transmitter idle, can accept |
| txd | output | 1 | Serial output, idles high |
| rxd | input | 1 | Serial input, asynchronous |
| rx_data | output | 8 | Received character |
| rx_valid | output | 1 | Received character held |
| rx_read | input | 1 | Consume held character |
| rx_perr | output | 1 | Parity error of held character |
| rx_ferr | output | 1 | Framing error of held character |
| rx_brk | output | 1 | Held character was a break |
| rx_ovf | output | 1 | A later character was dropped |

## Verification
The hardest situation to reach is the state after a break, where the input stays low past the end of the character. A receiver that forgot to wait there would frame a second all-low character on its own. The bench drives the input directly, reads the break, and then holds the line low for two hundred more ticks, which is longer than a full character. It checks that nothing arrives, and then checks that a normal character is received once the line is released. Overflow and mid-frame configuration changes are reached in loopback: in one case two characters are sent without a read, and in the other the configuration inputs are changed while a frame is still being shifted.

// File: rtl/serial_xcvr_pkg.sv
package serial_xcvr_pkg;

    localparam int CHAR_MAX = 8;

    typedef enum logic [1:0] {
        PAR_NONE  = 2'd0,
        PAR_EVEN  = 2'd1,
        PAR_ODD   = 2'd2,
        PAR_FORCE = 2'd3
    } par_mode_e;

    typedef struct packed {
        logic [1:0] len;
        par_mode_e  par;
        logic       stick;
        logic [1:0] stop;
    } frame_cfg_t;

    // parity bit expected for data whose unused upper bits are zero
    function automatic logic par_expect(input frame_cfg_t c, input logic [CHAR_MAX-1:0] d);
        case (c.par)
            PAR_EVEN: return ^d;
            PAR_ODD:  return ~^d;
            default:  return c.stick;
        endcase
    endfunction

endpackage

// File: rtl/sx_tx.sv
module sx_tx
    import serial_xcvr_pkg::*;
#(
    parameter int OSR = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick,
    input  frame_cfg_t          cfg,
    input  logic [CHAR_MAX-1:0] data,
    input  logic                valid,
    output logic                ready,
    output logic                txd,
    output logic                busy
);
    localparam int CW = $clog2(2 * OSR);
    localparam logic [CW-1:0] BIT_LAST = CW'(OSR - 1);

    typedef enum logic [2:0] {T_IDLE, T_START, T_DATA, T_PAR, T_STOP} tx_st_e;

    typedef struct packed {
        tx_st_e              st;
        logic [CW-1:0]       cnt;
        logic [2:0]          idx;
        logic [CHAR_MAX-1:0] sh;
        logic                acc;
    } tx_s;

    tx_s q, d;
    logic [CW-1:0] stop_last;
    logic [2:0]    idx_last;
    logic          par_out;

    always_comb begin
        case (cfg.stop)
            2'd0:    stop_last = CW'(OSR - 1);
            2'd1:    stop_last = CW'(OSR + OSR / 2 - 1);
            default: stop_last = CW'(2 * OSR - 1);
        endcase
        idx_last = 3'd4 + {1'b0, cfg.len};
        case (cfg.par)
            PAR_EVEN: par_out = q.acc;
            PAR_ODD:  par_out = ~q.acc;
            default:  par_out = cfg.stick;
        endcase

        d = q;
        if (q.st == T_IDLE) begin
            if (valid) begin
                d.st  = T_START;
                d.cnt = '0;
                d.idx = '0;
                d.sh  = data;
                d.acc = 1'b0;
            end
        end else if (tick) begin
            d.cnt = q.cnt + 1'b1;
            case (q.st)
                T_START: if (q.cnt == BIT_LAST) begin
                    d.cnt = '0;
                    d.st  = T_DATA;
                end
                T_DATA: if (q.cnt == BIT_LAST) begin
                    d.cnt = '0;
                    d.acc = q.acc ^ q.sh[0];
                    d.sh  = q.sh >> 1;
                    d.idx = q.idx + 1'b1;
                    if (q.idx == idx_last)
                        d.st = (cfg.par == PAR_NONE) ? T_STOP : T_PAR;
                end
                T_PAR: if (q.cnt == BIT_LAST) begin
                    d.cnt = '0;
                    d.st  = T_STOP;
                end
                T_STOP: if (q.cnt == stop_last) d.st = T_IDLE;
                default: d.st = T_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: T_IDLE, cnt: '0, idx: '0, sh: '0, acc: 1'b0};
        else        q <= d;
    end

    always_comb begin
        case (q.st)
            T_START: txd = 1'b0;
            T_DATA:  txd = q.sh[0];
            T_PAR:   txd = par_out;
            default: txd = 1'b1;
        endcase
    end

    assign ready = (q.st == T_IDLE);
    assign busy  = (q.st != T_IDLE);

endmodule

// File: rtl/sx_rx.sv
module sx_rx
    import serial_xcvr_pkg::*;
#(
    parameter int OSR = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick,
    input  frame_cfg_t          cfg,
    input  logic                rxd,
    input  logic                rd,
    output logic [CHAR_MAX-1:0] data,
    output logic                vld,
    output logic                perr,
    output logic                ferr,
    output logic                brk,
    output logic                ovf,
    output logic                busy
);
    localparam int CW = $clog2(OSR);
    localparam logic [CW-1:0] MID  = CW'(OSR / 2 - 1);
    localparam logic [CW-1:0] LAST = CW'(OSR - 1);

    typedef enum logic [2:0] {R_IDLE, R_START, R_DATA, R_PAR, R_STOP, R_BRK} rx_st_e;

    typedef struct packed {
        logic [1:0]          sync;
        rx_st_e              st;
        logic [CW-1:0]       cnt;
        logic [2:0]          idx;
        logic [CHAR_MAX-1:0] sh;
        logic                psmp;
        logic                zero;
        logic [CHAR_MAX-1:0] data;
        logic                vld;
        logic                perr;
        logic                ferr;
        logic                brk;
        logic                ovf;
    } rx_s;

    rx_s q, d;
    logic       rx_s_line;
    logic [2:0] idx_last;

    assign rx_s_line = q.sync[1];

    always_comb begin
        idx_last = 3'd4 + {1'b0, cfg.len};
        d = q;
        d.sync = {q.sync[0], rxd};
        if (rd) begin
            d.vld = 1'b0;
            d.ovf = 1'b0;
        end
        if (tick) begin
            case (q.st)
                R_IDLE: if (!rx_s_line) begin
                    d.st  = R_START;
                    d.cnt = '0;
                end
                R_START: begin
                    d.cnt = q.cnt + 1'b1;
                    if (q.cnt == MID && rx_s_line) d.st = R_IDLE;
                    else if (q.cnt == LAST) begin
                        d.st   = R_DATA;
                        d.cnt  = '0;
                        d.idx  = '0;
                        d.sh   = '0;
                        d.zero = 1'b1;
                    end
                end
                R_DATA: begin
                    d.cnt = q.cnt + 1'b1;
                    if (q.cnt == MID) begin
                        d.sh[q.idx] = rx_s_line;
                        if (rx_s_line) d.zero = 1'b0;
                    end
                    if (q.cnt == LAST) begin
                        d.cnt = '0;
                        d.idx = q.idx + 1'b1;
                        if (q.idx == idx_last)
                            d.st = (cfg.par == PAR_NONE) ? R_STOP : R_PAR;
                    end
                end
                R_PAR: begin
                    d.cnt = q.cnt + 1'b1;
                    if (q.cnt == MID) begin
                        d.psmp = rx_s_line;
                        if (rx_s_line) d.zero = 1'b0;
                    end
                    if (q.cnt == LAST) begin
                        d.cnt = '0;
                        d.st  = R_STOP;
                    end
                end
                R_STOP: begin
                    d.cnt = q.cnt + 1'b1;
                    if (q.cnt == MID) begin
                        d.st = (!rx_s_line && q.zero) ? R_BRK : R_IDLE;
                        if (q.vld && !rd) begin
                            d.ovf = 1'b1;
                        end else begin
                            d.vld  = 1'b1;
                            d.data = q.sh;
                            d.perr = (cfg.par != PAR_NONE) && (q.psmp != par_expect(cfg, q.sh));
                            d.ferr = !rx_s_line;
                            d.brk  = !rx_s_line && q.zero;
                        end
                    end
                end
                R_BRK: if (rx_s_line) d.st = R_IDLE;
                default: d.st = R_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            q <= '{sync: 2'b11, st: R_IDLE, cnt: '0, idx: '0, sh: '0, psmp: 1'b0,
                   zero: 1'b0, data: '0, vld: 1'b0, perr: 1'b0, ferr: 1'b0,
                   brk: 1'b0, ovf: 1'b0};
        else
            q <= d;
    end

    assign data = q.data;
    assign vld  = q.vld;
    assign perr = q.perr;
    assign ferr = q.ferr;
    assign brk  = q.brk;
    assign ovf  = q.ovf;
    assign busy = (q.st != R_IDLE);

endmodule

// File: rtl/serial_xcvr.sv
module serial_xcvr
    import serial_xcvr_pkg::*;
#(
    parameter int OSR = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick16,
    input  logic [1:0] cfg_len,
    input  logic [1:0] cfg_par,
    input  logic       cfg_stick,
    input  logic [1:0] cfg_stop,
    input  logic [7:0] tx_data,
    input  logic       tx_valid,
    output logic       tx_ready,
    output logic       txd,
    input  logic       rxd,
    output logic [7:0] rx_data,
    output logic       rx_valid,
    input  logic       rx_read,
    output logic       rx_perr,
    output logic       rx_ferr,
    output logic       rx_brk,
    output logic       rx_ovf
);
    typedef struct packed {
        frame_cfg_t cfg;
    } top_s;

    top_s q, d;
    logic tx_busy, rx_busy;

    always_comb begin
        d = q;
        if (!tx_busy && !rx_busy) begin
            d.cfg.len   = cfg_len;
            d.cfg.par   = par_mode_e'(cfg_par);
            d.cfg.stick = cfg_stick;
            d.cfg.stop  = cfg_stop;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{cfg: '{len: 2'd3, par: PAR_NONE, stick: 1'b0, stop: 2'd0}};
        else        q <= d;
    end

    sx_tx #(.OSR(OSR)) u_tx (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick16),
        .cfg   (q.cfg),
        .data  (tx_data),
        .valid (tx_valid),
        .ready (tx_ready),
        .txd   (txd),
        .busy  (tx_busy)
    );

    sx_rx #(.OSR(OSR)) u_rx (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick16),
        .cfg   (q.cfg),
        .rxd   (rxd),
        .rd    (rx_read),
        .data  (rx_data),
        .vld   (rx_valid),
        .perr  (rx_perr),
        .ferr  (rx_ferr),
        .brk   (rx_brk),
        .ovf   (rx_ovf),
        .busy  (rx_busy)
    );

endmodule

// File: rtl/serial_xcvr_chk.sv
module serial_xcvr_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       tx_valid,
    input logic       tx_ready,
    input logic       txd,
    input logic [7:0] rx_data,
    input logic       rx_valid,
    input logic       rx_read,
    input logic       rx_ferr,
    input logic       rx_brk,
    input logic       rx_ovf
);
    assert_idle_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ready |-> txd);

    assert_start_after_accept_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready) |=> (!tx_ready && !txd));

    assert_hold_until_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !rx_read) |=> (rx_valid && $stable(rx_data)));

    assert_break_shape_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_brk) |-> (rx_ferr && rx_data == 8'h00));

    assert_no_overflow_without_data_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rx_ovf |-> rx_valid);

    assert_read_clears_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rx_read |=> !rx_ovf);

endmodule

bind serial_xcvr serial_xcvr_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tx_valid (tx_valid),
    .tx_ready (tx_ready),
    .txd      (txd),
    .rx_data  (rx_data),
    .rx_valid (rx_valid),
    .rx_read  (rx_read),
    .rx_ferr  (rx_ferr),
    .rx_brk   (rx_brk),
    .rx_ovf   (rx_ovf)
);

// File: tb/serial_xcvr_bench.sv
module serial_xcvr_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick16 = 1'b0;
    logic [1:0] cfg_len = 2'd3;
    logic [1:0] cfg_par = 2'd0;
    logic       cfg_stick = 1'b0;
    logic [1:0] cfg_stop = 2'd0;
    logic [7:0] tx_data = 8'h00;
    logic       tx_valid = 1'b0;
    logic       tx_ready, txd;
    logic       loop = 1'b1;
    logic       rx_drv = 1'b1;
    logic       rxd;
    logic       rx_read = 1'b0;
    logic [7:0] rx_data;
    logic       rx_valid, rx_perr, rx_ferr, rx_brk, rx_ovf;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    assign rxd = loop ? txd : rx_drv;

    serial_xcvr u_serial_xcvr (
        .clk(clk), .rst_n(rst_n), .tick16(tick16),
        .cfg_len(cfg_len), .cfg_par(cfg_par), .cfg_stick(cfg_stick), .cfg_stop(cfg_stop),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready), .txd(txd),
        .rxd(rxd), .rx_data(rx_data), .rx_valid(rx_valid), .rx_read(rx_read),
        .rx_perr(rx_perr), .rx_ferr(rx_ferr), .rx_brk(rx_brk), .rx_ovf(rx_ovf)
    );

    initial forever #2 clk = ~clk;

    initial forever begin
        @(posedge clk);
        #1 tick16 = ~tick16;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wait_ticks(input int n);
        int c = 0;
        while (c < n) begin
            @(negedge clk);
            if (tick16) c++;
        end
    endtask

    // send one character and decode txd independently at mid-bit
    task automatic send_char(input logic [7:0] dat, input int n, input int pm,
                             input logic stk, input int sm);
        int ticks = 0;
        logic [15:0] fr = '1;
        logic [7:0] m, act_d;
        int p, exp_ticks;
        logic expp;
        m = 8'hFF >> (8 - n);
        p = (pm != 0) ? 1 : 0;
        case (pm)
            1: expp = ^(dat & m);
            2: expp = ~^(dat & m);
            default: expp = stk;
        endcase
        exp_ticks = 16 * (1 + n + p) + ((sm == 0) ? 16 : (sm == 1) ? 24 : 32);
        @(negedge clk);
        while (!tx_ready) @(negedge clk);
        tx_data = dat;
        tx_valid = 1'b1;
        @(negedge clk);
        tx_valid = 1'b0;
        forever begin
            if (tx_ready) break;
            if (tick16) begin
                ticks++;
                if (ticks % 16 == 8 && ticks / 16 < 16) fr[ticks / 16] = txd;
            end
            @(negedge clk);
        end
        act_d = '0;
        for (int i = 0; i < n; i++) act_d[i] = fr[1 + i];
        chk("R1 start and data bits", {23'd0, fr[0], act_d}, {23'd0, 1'b0, dat & m});
        if (p != 0) chk("R2 parity bit", {31'd0, fr[1 + n]}, {31'd0, expp});
        chk("R3 stop level", {31'd0, fr[1 + n + p]}, 32'd1);
        chk("R3 frame length in ticks", ticks, exp_ticks);
    endtask

    task automatic expect_rx(input string req, input logic [7:0] dat, input logic pe,
                             input logic fe, input logic bk, input logic ov);
        int w = 0;
        while (!rx_valid && w < 4000) begin
            @(negedge clk);
            w++;
        end
        chk(req, {19'd0, rx_valid, rx_data, rx_perr, rx_ferr, rx_brk, rx_ovf},
                 {19'd0, 1'b1, dat, pe, fe, bk, ov});
        rx_read = 1'b1;
        @(negedge clk);
        rx_read = 1'b0;
        chk({req, " read clears"}, {30'd0, rx_valid, rx_ovf}, 32'd0);
    endtask

    function automatic logic [15:0] mkf(input logic [7:0] dat, input int n, input int hp,
                                        input logic pb, input logic sb);
        logic [15:0] f = '1;
        f[0] = 1'b0;
        for (int i = 0; i < n; i++) f[1 + i] = dat[i];
        if (hp != 0) f[1 + n] = pb;
        f[1 + n + hp] = sb;
        return f;
    endfunction

    task automatic rx_send(input logic [15:0] f, input int nb, input int last_ticks,
                           input logic end_lvl);
        for (int i = 0; i < nb; i++) begin
            rx_drv = f[i];
            wait_ticks((i == nb - 1) ? last_ticks : 16);
        end
        rx_drv = end_lvl;
    endtask

    task automatic set_cfg(input int l, input int pm, input logic stk, input int sm);
        cfg_len = 2'(l);
        cfg_par = 2'(pm);
        cfg_stick = stk;
        cfg_stop = 2'(sm);
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic summary;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog (run did not finish): actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        logic [7:0] pats [3];
        pats[0] = 8'h5A;
        pats[1] = 8'hFF;
        pats[2] = 8'h3C;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R4 ready after reset", {31'd0, tx_ready}, 32'd1);
        chk("R1 txd high after reset", {31'd0, txd}, 32'd1);
        chk("R5 no data after reset", {31'd0, rx_valid}, 32'd0);
        chk("R10 no overflow after reset", {31'd0, rx_ovf}, 32'd0);

        // loopback sweep over every format
        for (int l = 0; l < 4; l++)
            for (int pm = 0; pm < 4; pm++)
                for (int sm = 0; sm < 3; sm++)
                    for (int k = 0; k < 3; k++) begin
                        logic [7:0] dat;
                        logic stk;
                        int n;
                        n = 5 + l;
                        dat = pats[k] ^ 8'(l * 16 + pm * 4 + sm);
                        stk = k[0];
                        set_cfg(l, pm, stk, sm);
                        send_char(dat, n, pm, stk, sm);
                        expect_rx("R5 loopback character", dat & (8'hFF >> (8 - n)), 1'b0, 1'b0, 1'b0, 1'b0);
                    end

        // directed receive cases
        loop = 1'b0;
        set_cfg(3, 1, 1'b0, 0);
        rx_send(mkf(8'h37, 8, 1, 1'b0, 1'b1), 11, 16, 1'b1);
        expect_rx("R7 even parity wrong", 8'h37, 1'b1, 1'b0, 1'b0, 1'b0);
        set_cfg(3, 2, 1'b0, 0);
        rx_send(mkf(8'h37, 8, 1, 1'b0, 1'b1), 11, 16, 1'b1);
        expect_rx("R7 odd parity right", 8'h37, 1'b0, 1'b0, 1'b0, 1'b0);
        set_cfg(1, 3, 1'b1, 0);
        rx_send(mkf(8'h15, 6, 1, 1'b0, 1'b1), 9, 16, 1'b1);
        expect_rx("R7 forced level wrong", 8'h15, 1'b1, 1'b0, 1'b0, 1'b0);

        set_cfg(3, 0, 1'b0, 0);
        rx_send(mkf(8'h81, 8, 0, 1'b0, 1'b0), 10, 10, 1'b1);
        wait_ticks(30);
        expect_rx("R8 low stop bit", 8'h81, 1'b0, 1'b1, 1'b0, 1'b0);

        rx_send(16'h0000, 10, 16, 1'b0);
        expect_rx("R9 break delivered", 8'h00, 1'b0, 1'b1, 1'b1, 1'b0);
        wait_ticks(200);
        chk("R9 no character while line stays low", {31'd0, rx_valid}, 32'd0);
        rx_drv = 1'b1;
        wait_ticks(20);
        rx_send(mkf(8'h6E, 8, 0, 1'b0, 1'b1), 10, 16, 1'b1);
        expect_rx("R9 character after release", 8'h6E, 1'b0, 1'b0, 1'b0, 1'b0);

        rx_drv = 1'b0;
        wait_ticks(4);
        rx_drv = 1'b1;
        wait_ticks(40);
        chk("R6 short low pulse ignored", {31'd0, rx_valid}, 32'd0);
        rx_send(mkf(8'hC3, 8, 0, 1'b0, 1'b1), 10, 16, 1'b1);
        expect_rx("R6 character after pulse", 8'hC3, 1'b0, 1'b0, 1'b0, 1'b0);

        // overflow in loopback
        loop = 1'b1;
        set_cfg(3, 0, 1'b0, 0);
        send_char(8'h11, 8, 0, 1'b0, 0);
        send_char(8'h22, 8, 0, 1'b0, 0);
        expect_rx("R10 second character dropped", 8'h11, 1'b0, 1'b0, 1'b0, 1'b1);

        // configuration change during a frame
        fork
            send_char(8'hE7, 8, 0, 1'b0, 0);
            begin
                wait_ticks(40);
                cfg_len = 2'd0;
                cfg_par = 2'd2;
                cfg_stop = 2'd2;
            end
        join
        expect_rx("R11 frame kept its format", 8'hE7, 1'b0, 1'b0, 1'b0, 1'b0);
        send_char(8'hE7, 5, 2, 1'b0, 2);
        expect_rx("R11 next frame uses new format", 8'h07, 1'b0, 1'b0, 1'b0, 1'b0);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule